// File: doc/BRIEF.md
# Battery-backed SRAM cartridge bus controller

This block sits on the host side of a bytewide, battery-backed static RAM cartridge. It turns single read and write requests from on-chip logic into the three active-low memory strobes (chip select, write strobe and output enable), together with a 15-bit address and a byte of write data. Each strobe phase lasts at least a minimum time. Every minimum is written as a nanosecond figure and converted to whole clock cycles, rounding up. The block does not include the bidirectional pad. It gives a separate output byte, an output-drive enable and an input byte, and the pad is built outside it.

Requests enter through a valid/ready handshake. `req_ready` is high only while the controller is idle. A requester that sees `req_ready` low keeps `req_valid` and its fields unchanged until a clock edge where both are high, and the request is taken at that edge. The response has no back-pressure. `rsp_valid` is a one-cycle pulse when a read byte is captured or a write has finished, and the consumer has to take it in that cycle. The cartridge density code is a plain control input. It is sampled when a request is accepted, and it clears the address lines that the fitted cartridge does not decode.

With the default parameters and an 8 ns clock, the phase lengths come to a 32-cycle read, a 22-cycle write strobe and a 9-cycle write tail.

Top module: `sram_cart_ctrl`

## Requirements
- R1: During and after reset, before any request: `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A read holds `mem_ce_n` and `mem_oe_n` low together, with `mem_we_n` high, for exactly RD_CYC cycles. RD_CYC is the largest of the rounded-up address-access, OE-access and read-cycle times. The byte on `mem_dq_in` in the last of those cycles is returned on `rsp_rdata`.
- R3: A write first spends one setup cycle with address and data driven and all strobes high. It then holds `mem_ce_n` and `mem_we_n` low together for exactly WP_CYC cycles. WP_CYC is the larger of the rounded-up write-pulse and data-setup times.
- R4: `mem_oe_n` stays 1 in every cycle of a write. `mem_dq_oe` is 1 from the setup cycle through the last tail cycle, and is 0 whenever the bus is not in a write.
- R5: After the write strobe, all strobes stay high for TAIL_CYC cycles while data is still driven. TAIL_CYC is the largest of the data-hold time, the write-recovery time, and the write-cycle time minus setup and strobe. `rsp_valid` rises in the cycle after the tail, so a write takes 1+WP_CYC+TAIL_CYC cycles.
- R6: `mem_addr` does not change while `mem_ce_n` is low.
- R7: The density code `cart_size` selects which address bits pass through: 0 keeps bits 10..0 (2K), 1 keeps bits 12..0 (8K), 2 keeps bits 13..0 (16K), and 3 or higher keeps all 15 bits. Bits that are not kept appear as 0 on `mem_addr`.
- R8: `req_ready` is 0 from the acceptance edge until the response. A request held valid during that time is not taken, and it is accepted at the first edge after `rsp_valid`.
- R9: `rsp_valid` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cart_size | input | 3 | Cartridge density code, sampled at acceptance |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 15 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 15 | Masked address to the cartridge |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte to drive onto the data pads |
| mem_dq_oe | output | 1 | Drive enable for the data pads |
| mem_dq_in | input | 8 | Byte read from the data pads |

## Verification
The bench uses the default nanosecond minimums and an 8 ns clock period. Each rounding-up then gives a different cycle count: 32 read cycles, 22 strobe cycles and 9 tail cycles, where the write-cycle time rather than the hold or recovery time sets the tail. Because these counts differ, an off-by-one in any single phase length shows up as a wrong count. Every density code from 0 to 4 is driven with an all-ones address, which reaches each mask boundary. A write made under the smallest density is read back at the aliased low address under the full density.

// File: rtl/sram_cart_pkg.sv
package sram_cart_pkg;

  typedef enum logic [2:0] {
    SZ_2K  = 3'd0,
    SZ_8K  = 3'd1,
    SZ_16K = 3'd2,
    SZ_24K = 3'd3,
    SZ_32K = 3'd4
  } cart_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WTAIL
  } ctrl_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cart_addr_mask.sv
module cart_addr_mask
  import sram_cart_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic [2:0]    size_code,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);

  localparam int LIM_W = $clog2(AW + 1);

  logic [LIM_W-1:0] keep_bits;

  always_comb begin
    case (size_code)
      SZ_2K:   keep_bits = LIM_W'(11);
      SZ_8K:   keep_bits = LIM_W'(13);
      SZ_16K:  keep_bits = LIM_W'(14);
      default: keep_bits = LIM_W'(AW);
    endcase
  end

  for (genvar i = 0; i < AW; i++) begin : g_bit
    assign addr_out[i] = addr_in[i] & (keep_bits > LIM_W'(i));
  end

endmodule

// File: rtl/cart_phase_timer.sv
module cart_phase_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          last
);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign last = (cnt == '0);

endmodule

// File: rtl/sram_cart_ctrl.sv
module sram_cart_ctrl
  import sram_cart_pkg::*;
#(
  parameter int AW      = 15,
  parameter int DW      = 8,
  parameter int CLK_NS  = 8,
  parameter int T_ACC   = 250,
  parameter int T_OEA   = 125,
  parameter int T_RC    = 250,
  parameter int T_WP    = 170,
  parameter int T_WC    = 250,
  parameter int T_DS    = 100,
  parameter int T_DH    = 20,
  parameter int T_WR    = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    cart_size,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);

  localparam int RD_CYC = imax(imax(ns_to_cyc(T_ACC, CLK_NS), ns_to_cyc(T_OEA, CLK_NS)),
                               ns_to_cyc(T_RC, CLK_NS));
  localparam int WP_CYC = imax(ns_to_cyc(T_WP, CLK_NS), ns_to_cyc(T_DS, CLK_NS));
  localparam int TAIL_CYC = imax(imax(imax(ns_to_cyc(T_DH, CLK_NS), ns_to_cyc(T_WR, CLK_NS)),
                                      ns_to_cyc(T_WC, CLK_NS) - 1 - WP_CYC), 1);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), TAIL_CYC);
  localparam int TW = $clog2(MAX_CYC + 1);

  ctrl_state_e   state;
  logic [AW-1:0] masked_addr;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_last;

  cart_addr_mask #(.AW(AW)) u_mask (
    .size_code (cart_size),
    .addr_in   (req_addr),
    .addr_out  (masked_addr)
  );

  cart_phase_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  assign req_ready = (state == ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE:   if (req_valid && !req_write) begin
                   tmr_load = 1'b1;
                   tmr_val  = TW'(RD_CYC - 1);
                 end
      ST_WSETUP: begin
                   tmr_load = 1'b1;
                   tmr_val  = TW'(WP_CYC - 1);
                 end
      ST_WPULSE: if (tmr_last) begin
                   tmr_load = 1'b1;
                   tmr_val  = TW'(TAIL_CYC - 1);
                 end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_ce_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          mem_addr <= masked_addr;
          if (req_write) begin
            mem_dq_out <= req_wdata;
            mem_dq_oe  <= 1'b1;
            state      <= ST_WSETUP;
          end else begin
            mem_ce_n <= 1'b0;
            mem_oe_n <= 1'b0;
            state    <= ST_READ;
          end
        end
        ST_READ: if (tmr_last) begin
          rsp_rdata <= mem_dq_in;
          rsp_valid <= 1'b1;
          mem_ce_n  <= 1'b1;
          mem_oe_n  <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_WSETUP: begin
          mem_ce_n <= 1'b0;
          mem_we_n <= 1'b0;
          state    <= ST_WPULSE;
        end
        ST_WPULSE: if (tmr_last) begin
          mem_ce_n <= 1'b1;
          mem_we_n <= 1'b1;
          state    <= ST_WTAIL;
        end
        ST_WTAIL: if (tmr_last) begin
          mem_dq_oe <= 1'b0;
          rsp_valid <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Observation counters for the duration assertions
  logic [15:0] we_run;
  logic [15:0] rd_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      we_run <= '0;
      rd_run <= '0;
    end else begin
      we_run <= !mem_we_n ? we_run + 16'd1 : 16'd0;
      rd_run <= (!mem_ce_n && !mem_oe_n) ? rd_run + 16'd1 : 16'd0;
    end
  end

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n)); // R1
  AST_RD_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R2
  AST_RD_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |-> (rd_run == 16'(RD_CYC))); // R2
  AST_WE_WITH_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n); // R3
  AST_WE_LEN: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (we_run == 16'(WP_CYC))); // R3
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_dq_oe); // R5
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R6
  AST_MASK_2K: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(req_ready) && $past(cart_size) == 3'd0 && $past(req_valid))
      |-> (mem_addr >> 11) == '0); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !mem_ce_n |-> !req_ready); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9

endmodule

// File: tb/test_sram_cart_ctrl.sv
`timescale 1ns/1ps
module test_sram_cart_ctrl;

  localparam int RD_EXP   = 32;
  localparam int WP_EXP   = 22;
  localparam int TAIL_EXP = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cart_size = 3'd4;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [14:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_dq_in;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sram_cart_ctrl i_sram_cart_ctrl (
    .clk(clk), .rst(rst), .cart_size(cart_size),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  // Behavioural cartridge memory
  logic [7:0]  mem_store [int];
  logic        we_was_low = 1'b0;
  logic [14:0] wr_a = '0;
  logic [7:0]  wr_d = '0;
  logic [7:0]  rd_byte = '0;

  function automatic logic [7:0] pat(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]};
  endfunction

  always @(negedge clk) begin
    if (we_was_low && mem_we_n) mem_store[int'(wr_a)] = wr_d;
    we_was_low = !mem_we_n && !mem_ce_n;
    if (we_was_low) begin
      wr_a = mem_addr;
      wr_d = mem_dq_out;
    end
    rd_byte = mem_store.exists(int'(mem_addr)) ? mem_store[int'(mem_addr)] : pat(mem_addr);
  end
  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? rd_byte : 8'h00;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Observations of the last operation
  int n_setup, n_ce, n_we, n_oe, n_tail, n_total, n_oe_in_wr, rsp_w;
  bit addr_moved;
  logic [14:0] addr_seen;
  logic [7:0]  rdata_seen;

  task automatic run_op(input bit wr, input logic [14:0] a, input logic [7:0] d,
                        input logic [2:0] sz);
    bit seen_we;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; cart_size = sz;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
    n_setup = 0; n_ce = 0; n_we = 0; n_oe = 0; n_tail = 0; n_total = 0;
    n_oe_in_wr = 0; addr_moved = 1'b0; seen_we = 1'b0;
    @(negedge clk);
    addr_seen = mem_addr;
    while (!rsp_valid && n_total < 1000) begin
      n_total++;
      if (!mem_ce_n) n_ce++;
      if (!mem_we_n) begin n_we++; seen_we = 1'b1; end
      if (!mem_oe_n) n_oe++;
      if (wr && !mem_oe_n) n_oe_in_wr++;
      if (mem_dq_oe && mem_ce_n && !seen_we) n_setup++;
      if (mem_dq_oe && mem_ce_n && seen_we) n_tail++;
      if (mem_addr != addr_seen) addr_moved = 1'b1;
      @(negedge clk);
    end
    n_total++;
    rdata_seen = rsp_rdata;
    @(negedge clk);
    rsp_w = rsp_valid ? 2 : 1;
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
    chk({mem_ce_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes", int'({mem_ce_n, mem_we_n, mem_oe_n}), 7);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe", int'(mem_dq_oe), 0);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
  endtask

  task automatic t_read(input logic [14:0] a, input logic [7:0] exp);
    run_op(1'b0, a, 8'h00, 3'd4);
    chk(n_ce == RD_EXP, "R2 ce low cycles", n_ce, RD_EXP);
    chk(n_oe == RD_EXP, "R2 oe low cycles", n_oe, RD_EXP);
    chk(n_we == 0, "R2 we stays high", n_we, 0);
    chk(rdata_seen == exp, "R2 read data", int'(rdata_seen), int'(exp));
    chk(n_total == RD_EXP + 1, "R2 read latency", n_total, RD_EXP + 1);
    chk(!addr_moved && addr_seen == a, "R6 address held", int'(addr_seen), int'(a));
    chk(rsp_w == 1, "R9 pulse width", rsp_w, 1);
  endtask

  task automatic t_write(input logic [14:0] a, input logic [7:0] d);
    run_op(1'b1, a, d, 3'd4);
    chk(n_setup == 1, "R3 setup cycle", n_setup, 1);
    chk(n_we == WP_EXP && n_ce == WP_EXP, "R3 strobe cycles", n_we, WP_EXP);
    chk(n_oe_in_wr == 0, "R4 oe high in write", n_oe_in_wr, 0);
    chk(n_tail == TAIL_EXP, "R5 tail cycles", n_tail, TAIL_EXP);
    chk(n_total == 1 + WP_EXP + TAIL_EXP + 1, "R5 write latency", n_total, 1 + WP_EXP + TAIL_EXP + 1);
    chk(mem_dq_oe == 1'b0, "R4 bus released", int'(mem_dq_oe), 0);
    chk(!addr_moved, "R6 address held in write", int'(addr_moved), 0);
    chk(rsp_w == 1, "R9 write pulse width", rsp_w, 1);
    t_read(a, d);
  endtask

  task automatic t_density();
    logic [14:0] exp_a [5];
    exp_a[0] = 15'h07FF; exp_a[1] = 15'h1FFF; exp_a[2] = 15'h3FFF;
    exp_a[3] = 15'h7FFF; exp_a[4] = 15'h7FFF;
    for (int s = 0; s < 5; s++) begin
      run_op(1'b0, 15'h7FFF, 8'h00, 3'(s));
      chk(addr_seen == exp_a[s], "R7 masked address", int'(addr_seen), int'(exp_a[s]));
    end
    run_op(1'b1, 15'h7801, 8'h3C, 3'd0);
    chk(addr_seen == 15'h0001, "R7 write alias", int'(addr_seen), 1);
    run_op(1'b0, 15'h0001, 8'h00, 3'd4);
    chk(rdata_seen == 8'h3C, "R7 aliased read back", int'(rdata_seen), 8'h3C);
  endtask

  task automatic t_busy();
    int ready_busy = 0;
    int waited = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 15'h0222; cart_size = 3'd4;
    @(posedge clk); #1;
    req_addr = 15'h0333;
    @(negedge clk);
    while (!rsp_valid && waited < 1000) begin
      if (req_ready) ready_busy++;
      waited++;
      @(negedge clk);
    end
    chk(ready_busy == 0, "R8 not ready while busy", ready_busy, 0);
    chk(req_ready == 1'b1, "R8 ready at response", int'(req_ready), 1);
    chk(rdata_seen !== 8'hxx && rsp_rdata == pat(15'h0222), "R8 first read data",
        int'(rsp_rdata), int'(pat(15'h0222)));
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_ce_n && mem_addr == 15'h0333, "R8 held request taken next", int'(mem_addr), 15'h0333);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_rdata == pat(15'h0333), "R8 second read data", int'(rsp_rdata), int'(pat(15'h0333)));
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(15'h1234, pat(15'h1234));
    t_write(15'h0155, 8'hA5);
    t_write(15'h7FFE, 8'hFF);
    t_write(15'h0000, 8'h00);
    t_density();
    t_busy();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule